// File: doc/BRIEF.md
# Masked packed logical left shifter

This block is one pipeline stage of a SIMD execution unit. It takes a source vector of up to 512 bits, divides it into 16-, 32- or 64-bit elements, and shifts every element left by one shared count. The low bits left empty by the shift are filled with zeros. The count comes either from the low half of a 128-bit register operand or from an 8-bit immediate. The count is compared as a whole unsigned number, so any count larger than the element's top bit index clears the element. It never wraps around.

An active vector length of 128, 256 or 512 bits selects how many lanes take part. Every bit above that length is returned as zero. A per-lane writemask can be enabled. Lanes whose mask bit is clear either keep the matching lane of an old destination vector (merge) or become zero (zero). For 32- and 64-bit elements, a broadcast option feeds source element 0 to every lane. The result is registered, and a valid strobe marks it one cycle after the request.

Top module: `shl_top`

## Requirements
- R1: Each element is shifted left by the count, and zeros enter at the low end. `elemSel` selects the element size: 0 = 16 bits, 1 = 32 bits, 2 or 3 = 64 bits.
- R2: If the count exceeds 15, 31 or 63 for 16-, 32- or 64-bit elements, every active lane's shifted value is 0. All 64 count bits take part in this comparison, so a count such as 2^32+1 also clears the lanes.
- R3: When `useImm` is 0, the count is `cntReg[63:0]`. The bits `cntReg[127:64]` have no effect on the result.
- R4: When `useImm` is 1, the count is the unsigned 8-bit `cntImm`, and `cntReg` has no effect. The rule of R2 applies to it in the same way.
- R5: When `maskEn` is 0, every active lane takes its shifted value. When `maskEn` is 1, lane j takes its shifted value only if `mask[j]` is 1. Lanes are numbered from bit 0 upward.
- R6: When `maskEn` is 1 and lane j has `mask[j]` = 0, the lane holds the matching lane of `oldDst` if `zeroMode` is 0, and holds 0 if `zeroMode` is 1.
- R7: `lenSel` selects the active length: 0 = 128 bits, 1 = 256 bits, 2 or 3 = 512 bits. Result bits at and above the active length are 0. Mask bits at or above the active lane count are ignored.
- R8: When `bcastEn` is 1 with 32- or 64-bit elements, every lane shifts source element 0 (the lowest bits of `srcVec`). With 16-bit elements, `bcastEn` has no effect.
- R9: `outValid` is 1 exactly in the cycle after a cycle with `inValid` = 1. `result` changes only after such a cycle and otherwise holds its value. A synchronous active-high reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| elemSel | input | 2 | Element size code |
| lenSel | input | 2 | Active vector length code |
| useImm | input | 1 | 1 selects the immediate count |
| cntReg | input | 128 | Register count operand (low 64 bits used) |
| cntImm | input | 8 | Immediate count |
| maskEn | input | 1 | Enables the per-lane writemask |
| zeroMode | input | 1 | 1 = masked-off lanes become zero, 0 = they merge |
| bcastEn | input | 1 | Broadcast source element 0 |
| mask | input | 32 | Per-lane writemask |
| srcVec | input | 512 | Source vector |
| oldDst | input | 512 | Old destination used for merging |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 512 | Registered result |

## Verification
The assertions assume that the request fields are stable while `inValid` is high, and that reset is held from time zero until the first clocked cycle. The merge and zero-mode properties only fire when the whole mask is clear. The pass-through property only fires for a zero low count with a nonzero upper half. The stimulus drives all fields in one go on the falling clock edge. It keeps the fields constant through each rising edge, and applies junk values only while `inValid` is low. This matches what the properties assume.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int VEC_W    = 512;
  localparam int GRAN_W   = 16;
  localparam int NUM_GRAN = VEC_W / GRAN_W;
  localparam int CNT_W    = 64;
  localparam int SH_W     = $clog2(CNT_W);
  localparam int GRAN_CW  = $clog2(NUM_GRAN) + 1;

  // Code 3 on the select input is folded to ELEM64 by the control.
  typedef enum logic [1:0] {
    ELEM16 = 2'd0,
    ELEM32 = 2'd1,
    ELEM64 = 2'd2
  } elem_e;

  typedef struct packed {
    elem_e               elem;
    logic                bcast;
    logic                clearAll;
    logic [SH_W-1:0]     shAmt;
    logic [NUM_GRAN-1:0] takeNew;
    logic [NUM_GRAN-1:0] keepOld;
  } shlStrobe_t;
endpackage

// File: rtl/shl_ctrl.sv
module shl_ctrl
  import shl_pkg::*;
(
  input  logic [1:0]          elemSel,
  input  logic [1:0]          lenSel,
  input  logic                useImm,
  input  logic [CNT_W-1:0]    cntLo,
  input  logic [7:0]          cntImm,
  input  logic                maskEn,
  input  logic                zeroMode,
  input  logic                bcastEn,
  input  logic [NUM_GRAN-1:0] mask,
  output shlStrobe_t          strobe
);
  logic [CNT_W-1:0]    count;
  elem_e               elem;
  logic [GRAN_CW-1:0]  activeGran;
  logic                overRange;
  logic [NUM_GRAN-1:0] laneBit;
  logic [NUM_GRAN-1:0] active;

  always_comb begin
    count = useImm ? {{(CNT_W-8){1'b0}}, cntImm} : cntLo;
    case (elemSel)
      2'd0:    elem = ELEM16;
      2'd1:    elem = ELEM32;
      default: elem = ELEM64;
    endcase
    case (lenSel)
      2'd0:    activeGran = GRAN_CW'(NUM_GRAN / 4);
      2'd1:    activeGran = GRAN_CW'(NUM_GRAN / 2);
      default: activeGran = GRAN_CW'(NUM_GRAN);
    endcase
    case (elem)
      ELEM16:  overRange = |count[CNT_W-1:4];
      ELEM32:  overRange = |count[CNT_W-1:5];
      default: overRange = |count[CNT_W-1:6];
    endcase
  end

  // Map each 16-bit granule to the mask bit of the lane that owns it.
  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
    assign laneBit[g] = (elem == ELEM16) ? mask[g] :
                        (elem == ELEM32) ? mask[g/2] : mask[g/4];
    assign active[g]  = (GRAN_CW'(g) < activeGran);
  end

  always_comb begin
    strobe.elem     = elem;
    strobe.bcast    = bcastEn && (elem != ELEM16);
    strobe.clearAll = overRange;
    strobe.shAmt    = count[SH_W-1:0];
    strobe.takeNew  = active & ~({NUM_GRAN{maskEn}} & ~laneBit);
    strobe.keepOld  = active & {NUM_GRAN{maskEn & ~zeroMode}} & ~laneBit;
  end

  // A granule is never both written with the new value and kept from the old one.
  always_comb begin
    AST_TAKE_KEEP_EXCL: assert ((strobe.takeNew & strobe.keepOld) == '0); // R6
  end
endmodule

// File: rtl/shl_datapath.sv
module shl_datapath
  import shl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  shlStrobe_t       strobe,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] oldDst,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] srcEff;
  logic [VEC_W-1:0] sh16;
  logic [VEC_W-1:0] sh32;
  logic [VEC_W-1:0] sh64;
  logic [VEC_W-1:0] shifted;
  logic [VEC_W-1:0] nextRes;

  always_comb begin
    case (strobe.elem)
      ELEM32:  srcEff = strobe.bcast ? {(VEC_W/32){srcVec[31:0]}} : srcVec;
      ELEM64:  srcEff = strobe.bcast ? {(VEC_W/64){srcVec[63:0]}} : srcVec;
      default: srcEff = srcVec;
    endcase
  end

  for (genvar w = 0; w < VEC_W/16; w++) begin : g_w16
    assign sh16[w*16 +: 16] = srcEff[w*16 +: 16] << strobe.shAmt[3:0];
  end
  for (genvar d = 0; d < VEC_W/32; d++) begin : g_w32
    assign sh32[d*32 +: 32] = srcEff[d*32 +: 32] << strobe.shAmt[4:0];
  end
  for (genvar q = 0; q < VEC_W/64; q++) begin : g_w64
    assign sh64[q*64 +: 64] = srcEff[q*64 +: 64] << strobe.shAmt;
  end

  always_comb begin
    if (strobe.clearAll) shifted = '0;
    else begin
      case (strobe.elem)
        ELEM16:  shifted = sh16;
        ELEM32:  shifted = sh32;
        default: shifted = sh64;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_sel
    assign nextRes[g*GRAN_W +: GRAN_W] =
      strobe.takeNew[g] ? shifted[g*GRAN_W +: GRAN_W] :
      strobe.keepOld[g] ? oldDst[g*GRAN_W +: GRAN_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= nextRes;
    end
  end

  AST_OUT_LAT: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result)); // R9
  AST_CLEAR_RANGE: assert property (@(posedge clk) disable iff (rst)
    inValid && strobe.clearAll && (strobe.keepOld == '0) |=> (result == '0)); // R2
endmodule

// File: rtl/shl_top.sv
module shl_top
  import shl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [1:0]         elemSel,
  input  logic [1:0]         lenSel,
  input  logic               useImm,
  input  logic [2*CNT_W-1:0] cntReg,
  input  logic [7:0]         cntImm,
  input  logic               maskEn,
  input  logic               zeroMode,
  input  logic               bcastEn,
  input  logic [NUM_GRAN-1:0] mask,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   oldDst,
  output logic               outValid,
  output logic [VEC_W-1:0]   result
);
  shlStrobe_t strobe;

  shl_ctrl u_ctrl (
    .elemSel  (elemSel),
    .lenSel   (lenSel),
    .useImm   (useImm),
    .cntLo    (cntReg[CNT_W-1:0]),
    .cntImm   (cntImm),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .bcastEn  (bcastEn),
    .mask     (mask),
    .strobe   (strobe)
  );

  shl_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .srcVec   (srcVec),
    .oldDst   (oldDst),
    .outValid (outValid),
    .result   (result)
  );

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    inValid && (lenSel == 2'd0) |=> (result[VEC_W-1:128] == '0)); // R7
  AST_ZERO_MODE: assert property (@(posedge clk) disable iff (rst)
    inValid && maskEn && zeroMode && (mask == '0) |=> (result == '0)); // R6
  AST_MERGE_ALL: assert property (@(posedge clk) disable iff (rst)
    inValid && maskEn && !zeroMode && (mask == '0) && lenSel[1]
    |=> (result == $past(oldDst))); // R6
  AST_CNT_HI_IGNORED: assert property (@(posedge clk) disable iff (rst)
    inValid && !useImm && (cntReg[CNT_W-1:0] == '0) && (cntReg[2*CNT_W-1:CNT_W] != '0)
    && !maskEn && !bcastEn && lenSel[1] |=> (result == $past(srcVec))); // R3
endmodule

// File: tb/shl_top_tb.sv
`timescale 1ns/100ps
module shl_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         inValid = 0;
  logic [1:0]   elemSel = 0, lenSel = 0;
  logic         useImm = 0, maskEn = 0, zeroMode = 0, bcastEn = 0;
  logic [127:0] cntReg = 0;
  logic [7:0]   cntImm = 0;
  logic [31:0]  mask = 0;
  logic [511:0] srcVec = 0, oldDst = 0;
  logic         outValid;
  logic [511:0] result;

  shl_top u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .elemSel(elemSel), .lenSel(lenSel),
    .useImm(useImm), .cntReg(cntReg), .cntImm(cntImm), .maskEn(maskEn),
    .zeroMode(zeroMode), .bcastEn(bcastEn), .mask(mask), .srcVec(srcVec),
    .oldDst(oldDst), .outValid(outValid), .result(result)
  );

  // stimulus staging fields
  int           eSel, lSel;
  logic         uImm, mEn, zM, bC;
  logic [127:0] cR;
  logic [7:0]   cI;
  logic [31:0]  mK;
  logic [511:0] sV, oD;

  int nVec = 0, nFail = 0;
  logic [511:0] expQ[$];
  string        tagQ[$];
  logic [511:0] lastExp = '0;

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [511:0] model(input int es, input int ls, input logic ui,
      input logic [127:0] cr, input logic [7:0] ci, input logic me, input logic zm,
      input logic bc, input logic [31:0] mk, input logic [511:0] src, input logic [511:0] old);
    int w, vl;
    logic [63:0] c, wm, e, v;
    logic [511:0] res;
    logic bce;
    w   = (es == 0) ? 16 : (es == 1) ? 32 : 64;
    vl  = (ls == 0) ? 128 : (ls == 1) ? 256 : 512;
    c   = ui ? {56'd0, ci} : cr[63:0];
    bce = bc && (w != 16);
    wm  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    res = '0;
    for (int l = 0; l < vl / w; l++) begin
      e = bce ? src[63:0] : 64'(src >> (l * w));
      e = e & wm;
      v = (c > 64'(w - 1)) ? 64'd0 : ((e << c[5:0]) & wm);
      if (me && !mk[l]) v = zm ? 64'd0 : (64'(old >> (l * w)) & wm);
      res = res | (512'(v) << (l * w));
    end
    return res;
  endfunction

  task automatic send(input string tag);
    @(negedge clk);
    inValid = 1; elemSel = 2'(eSel); lenSel = 2'(lSel); useImm = uImm; cntReg = cR;
    cntImm = cI; maskEn = mEn; zeroMode = zM; bcastEn = bC; mask = mK;
    srcVec = sV; oldDst = oD;
    expQ.push_back(model(eSel, lSel, uImm, cR, cI, mEn, zM, bC, mK, sV, oD));
    tagQ.push_back(tag);
  endtask

  task automatic defaults(input int es, input int ls, input logic [63:0] cnt);
    eSel = es; lSel = ls; uImm = 0; cR = {$urandom, $urandom, cnt}; cI = 8'($urandom);
    mEn = 0; zM = 0; bC = 0; mK = $urandom; sV = rnd512(); oD = rnd512();
  endtask

  // R9: idle cycles with junk inputs leave result held and outValid low
  task automatic idleCheck();
    @(negedge clk);
    inValid = 0; srcVec = rnd512(); oldDst = rnd512(); cntReg = '0; mask = '1;
    repeat (3) @(negedge clk);
    chk("R9 idle outValid", {511'd0, outValid}, 512'd0);
    chk("R9 idle hold", result, lastExp);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        chk("R9 spurious outValid", 512'd1, 512'd0);
      end else begin
        automatic logic [511:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        lastExp = e;
        chk(t, result, e);
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset outValid", {511'd0, outValid}, 512'd0);
    chk("R9 reset result", result, 512'd0);

    // R1 basic shifts, back-to-back
    defaults(0, 2, 64'd3);  send("R1 e16 cnt3");
    defaults(1, 1, 64'd7);  send("R1 e32 cnt7 L256");
    defaults(2, 2, 64'd63); send("R1 e64 cnt63");
    defaults(3, 2, 64'd17); send("R1 elem code3 cnt17");
    defaults(0, 2, 64'd15); send("R1 e16 cnt15");
    defaults(1, 2, 64'd0);  send("R1 e32 cnt0");
    idleCheck();

    // R2 out-of-range counts
    defaults(0, 2, 64'd16); send("R2 e16 cnt16");
    defaults(1, 2, 64'd32); send("R2 e32 cnt32");
    defaults(1, 2, 64'd31); send("R2 e32 cnt31");
    defaults(2, 2, 64'd64); send("R2 e64 cnt64");
    defaults(2, 2, 64'h1_0000_0001); send("R2 e64 cnt 2^32+1");
    defaults(0, 2, 64'h8000_0000_0000_0002); send("R2 e16 cnt top bit");
    idleCheck();

    // R3 upper count half ignored
    defaults(0, 2, 64'd4); cR[127:64] = 64'hFFFF_FFFF_FFFF_FFFF; send("R3 upper ones cnt4");
    defaults(2, 2, 64'd0); cR[127:64] = 64'h0000_0001_0000_0000; send("R3 upper set cnt0");

    // R4 immediate form
    defaults(1, 2, 64'hFFFF); uImm = 1; cI = 8'd5;   send("R4 imm5");
    defaults(2, 2, 64'd1);    uImm = 1; cI = 8'd200; send("R4 imm200");
    defaults(0, 2, 64'd99);   uImm = 1; cI = 8'd15;  send("R4 imm15");
    idleCheck();

    // R5 / R6 masking
    defaults(0, 2, 64'd2); mEn = 1; zM = 0; send("R5 R6 merge e16");
    defaults(1, 2, 64'd9); mEn = 1; zM = 1; send("R5 R6 zero e32");
    defaults(2, 2, 64'd1); mEn = 1; zM = 0; mK = '0; send("R6 merge all");
    defaults(2, 2, 64'd1); mEn = 1; zM = 1; mK = '0; send("R6 zero all");
    defaults(1, 2, 64'd40); mEn = 1; zM = 0; send("R6 merge with range clear");
    defaults(0, 2, 64'd1); mEn = 0; mK = '0; send("R5 mask disabled");

    // R7 vector length
    defaults(0, 0, 64'd3); mEn = 1; mK = 32'hFFFF_FF00; zM = 0; send("R7 L128 high mask ignored");
    defaults(1, 1, 64'd1); mEn = 1; mK = 32'hFFFF_FF0F; zM = 0; send("R7 L256 merge");
    defaults(2, 3, 64'd8); send("R7 len code3");
    defaults(2, 0, 64'd8); send("R7 L128 e64");
    idleCheck();

    // R8 broadcast
    defaults(1, 2, 64'd4); bC = 1; send("R8 bcast e32");
    defaults(2, 1, 64'd12); bC = 1; send("R8 bcast e64 L256");
    defaults(0, 2, 64'd4); bC = 1; send("R8 bcast e16 ignored");
    defaults(1, 2, 64'd3); bC = 1; mEn = 1; zM = 1; send("R8 bcast masked");

    // mixed sweep
    for (int i = 0; i < 40; i++) begin
      defaults(int'($urandom % 4), int'($urandom % 4), 64'($urandom % 80));
      uImm = 1'($urandom); mEn = 1'($urandom); zM = 1'($urandom); bC = 1'($urandom);
      send("R1 R5 mixed");
    end
    idleCheck();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule